// File: doc/BRIEF.md
# Key-protected watchdog timer

This block guards a processor against runaway software. A prescaler and a reloadable up-counter both advance on ticks from a slow, free-running oscillator. The oscillator is not part of the block: each of its ticks arrives as a one-cycle enable input in the system clock domain. Software must reload the counter before the counter wraps. If the counter wraps, the block raises a one-cycle reset request towards the core. It also drives an external reset line that is held active for a fixed number of oscillator ticks.

An 8-bit control register guards the block with two magic values. Writing the disable key stops the watchdog and clears both counters. The block comes out of reset holding the disable key, so it starts switched off. Any other value in the control register lets the watchdog run. A write to the counter is accepted only while the control register holds the unlock key. An accepted write loads the counter, clears the prescaler and sets the control register to 00h. The counter can be read at any time. In any cycle that reads or writes the counter, an oscillator tick is discarded, so the value that software sees never changes underneath it.

Software uses one register port. `regAddr` 0 selects the control register and `regAddr` 1 selects the counter. Write data is taken when `regWe` is high. A counter read is marked by `regRe`. Read data is combinational from the current state.

Top module: `wdog_keyed`

## Requirements
- R1: After reset the control register reads A5h, the counter reads 0, and both `coreRstReq` and `extRst` are low.
- R2: While the control register holds A5h, ticks leave the counter unchanged.
- R3: Writing A5h to the control register (`regAddr`=0) sets the counter and the prescaler to zero. After a later enable, the first counter increment needs a full 2^PRE_W ticks.
- R4: While the control register holds any value other than A5h, the counter increments once every 2^PRE_W accepted ticks.
- R5: A counter write (`regAddr`=1, `regWe`=1) while the control register holds 5Ah loads the counter from `regWdata`, clears the prescaler and sets the control register to 00h.
- R6: A counter write while the control register holds any value other than 5Ah changes neither the counter, nor the prescaler, nor the control register.
- R7: A tick that arrives in a cycle with a counter access (`regAddr`=1 together with `regWe` or `regRe`) is dropped and is not counted later.
- R8: A counter read has no effect on the control register or the prescaler.
- R9: With reload value V, the counter wraps on accepted tick number (2^CNT_W − V)·2^PRE_W. `coreRstReq` is then high for exactly the next cycle, the control register returns to A5h and the counter reads 0.
- R10: `extRst` goes high in the cycle after the wrap and stays high for PULSE_UNITS·2^PRE_W ticks. It drops right after the last of those ticks, and register writes do not shorten it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| oscTick | input | 1 | One-cycle tick from the slow oscillator |
| regAddr | input | 1 | 0 = control register, 1 = counter |
| regWe | input | 1 | Write strobe |
| regRe | input | 1 | Read strobe (marks a counter read) |
| regWdata | input | DW | Write data |
| regRdata | output | DW | Read data of the addressed register |
| coreRstReq | output | 1 | One-cycle reset request to the core |
| extRst | output | 1 | Stretched external reset output |

## Verification
Read data is combinational, so the bench samples it in the cycle of the read, before that cycle's edge. A register write shows up in read data from the next cycle. `coreRstReq` and `extRst` both come from registers. They change right after the edge of the wrapping tick, and `extRst` also changes right after the edge of the last pulse tick. Every check is made one time unit after the edge concerned.

The bench sweeps every reload value of a small configuration and samples each one tick before the wrap and at the wrap. Dropped ticks are told apart from deferred ones by counting the ticks up to the next increment.

// File: rtl/wdog_keyed_pkg.sv
package wdog_keyed_pkg;
  typedef struct packed {
    logic step;   // accepted tick: advance the prescaler
    logic clear;  // disable key written: zero the prescaler and the counter
    logic load;   // unlocked counter write
    logic fire;   // wrap: issue reset, start the pulse
  } wdStrobe_t;
endpackage

// File: rtl/wdog_keyed_ctl.sv
module wdog_keyed_ctl
  import wdog_keyed_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] DIS_KEY = 8'hA5,
  parameter logic [DW-1:0] UNL_KEY = 8'h5A
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          oscTick,
  input  logic          regAddr,
  input  logic          regWe,
  input  logic          regRe,
  input  logic [DW-1:0] regWdata,
  input  logic          preWrap,
  input  logic          cntWrap,
  output wdStrobe_t     strb,
  output logic [DW-1:0] ctrlVal
);
  logic [DW-1:0] ctrlQ;
  logic cntAccess, ctrlWrite, enabled;

  always_comb begin
    cntAccess  = regAddr & (regWe | regRe);
    ctrlWrite  = regWe & ~regAddr;
    enabled    = (ctrlQ != DIS_KEY);
    strb.step  = enabled & oscTick & ~cntAccess;
    strb.fire  = strb.step & preWrap & cntWrap;
    strb.clear = ctrlWrite & (regWdata == DIS_KEY);
    strb.load  = regWe & regAddr & (ctrlQ == UNL_KEY);
  end

  always_ff @(posedge clk) begin
    if (!rstN)          ctrlQ <= DIS_KEY;
    else if (strb.fire) ctrlQ <= DIS_KEY;
    else if (strb.load) ctrlQ <= '0;
    else if (ctrlWrite) ctrlQ <= regWdata;
  end

  assign ctrlVal = ctrlQ;

  // R6
  wrong_key_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr && ctrlQ != UNL_KEY) |=> $stable(ctrlQ));
  // R5
  unlock_clears_ctrl_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (ctrlQ == '0));
  // R9
  wrap_rearm_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.fire |=> (ctrlQ == DIS_KEY));
endmodule

// File: rtl/wdog_keyed_dp.sv
module wdog_keyed_dp
  import wdog_keyed_pkg::*;
#(
  parameter int PRE_W = 11,
  parameter int CNT_W = 8,
  parameter int DW = 8,
  parameter int PULSE_UNITS = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             oscTick,
  input  wdStrobe_t        strb,
  input  logic [DW-1:0]    regWdata,
  output logic             preWrap,
  output logic             cntWrap,
  output logic [CNT_W-1:0] cntVal,
  output logic             coreRst,
  output logic             extRstOut
);
  localparam int PW = $clog2(PULSE_UNITS + 1) + PRE_W;
  localparam logic [PW-1:0] PULSE_LOAD = PW'(PULSE_UNITS) << PRE_W;

  logic [PRE_W-1:0] preQ;
  logic [CNT_W-1:0] cntQ;
  logic [PW-1:0]    pulseQ;
  logic             coreQ;

  assign preWrap = &preQ;
  assign cntWrap = &cntQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preQ <= '0;
      cntQ <= '0;
    end else if (strb.fire || strb.clear) begin
      preQ <= '0;
      cntQ <= '0;
    end else if (strb.load) begin
      preQ <= '0;
      cntQ <= regWdata[CNT_W-1:0];
    end else if (strb.step) begin
      preQ <= preQ + 1'b1;
      if (preWrap) cntQ <= cntQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulseQ <= '0;
      coreQ  <= 1'b0;
    end else begin
      coreQ <= strb.fire;
      if (strb.fire)                       pulseQ <= PULSE_LOAD;
      else if (oscTick && pulseQ != '0)    pulseQ <= pulseQ - 1'b1;
    end
  end

  assign cntVal    = cntQ;
  assign coreRst   = coreQ;
  assign extRstOut = (pulseQ != '0);

  // R2
  idle_cnt_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.step && !strb.load && !strb.clear && !strb.fire) |=> $stable(cntQ));
  // R3
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (cntQ == '0 && preQ == '0));
  // R9
  core_inside_ext_chk: assert property (@(posedge clk) disable iff (!rstN)
    coreQ |-> extRstOut);
  // R10
  ext_end_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(extRstOut) |-> $past(oscTick));
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_keyed_pkg::*;
#(
  parameter int PRE_W = 11,
  parameter int CNT_W = 8,
  parameter int DW = 8,
  parameter int PULSE_UNITS = 16,
  parameter logic [DW-1:0] DIS_KEY = 8'hA5,
  parameter logic [DW-1:0] UNL_KEY = 8'h5A
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          oscTick,
  input  logic          regAddr,
  input  logic          regWe,
  input  logic          regRe,
  input  logic [DW-1:0] regWdata,
  output logic [DW-1:0] regRdata,
  output logic          coreRstReq,
  output logic          extRst
);
  wdStrobe_t        strb;
  logic             preWrap, cntWrap;
  logic [DW-1:0]    ctrlVal;
  logic [CNT_W-1:0] cntVal;

  wdog_keyed_ctl #(.DW(DW), .DIS_KEY(DIS_KEY), .UNL_KEY(UNL_KEY)) u_ctl (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .regAddr(regAddr),
    .regWe(regWe), .regRe(regRe), .regWdata(regWdata),
    .preWrap(preWrap), .cntWrap(cntWrap), .strb(strb), .ctrlVal(ctrlVal)
  );

  wdog_keyed_dp #(.PRE_W(PRE_W), .CNT_W(CNT_W), .DW(DW),
                  .PULSE_UNITS(PULSE_UNITS)) u_dp (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .strb(strb),
    .regWdata(regWdata), .preWrap(preWrap), .cntWrap(cntWrap),
    .cntVal(cntVal), .coreRst(coreRstReq), .extRstOut(extRst)
  );

  assign regRdata = regAddr ? DW'(cntVal) : ctrlVal;
endmodule

// File: tb/wdog_keyed_bench.sv
`timescale 1ns/1ps
module wdog_keyed_bench;
  localparam int PRE_W = 3;
  localparam int CNT_W = 4;
  localparam int PULSE_UNITS = 2;
  localparam int TPC = 1 << PRE_W;
  localparam int SPAN = 1 << CNT_W;
  localparam int PT = PULSE_UNITS * TPC;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic oscTick = 1'b0;
  logic regAddr = 1'b0;
  logic regWe = 1'b0;
  logic regRe = 1'b0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic coreRstReq, extRst;

  int nChecks = 0;
  int nErr = 0;
  logic [7:0] v;

  always #4 clk = ~clk;

  wdog_keyed #(.PRE_W(PRE_W), .CNT_W(CNT_W), .DW(8),
               .PULSE_UNITS(PULSE_UNITS)) u_wdog_keyed (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .regAddr(regAddr),
    .regWe(regWe), .regRe(regRe), .regWdata(regWdata),
    .regRdata(regRdata), .coreRstReq(coreRstReq), .extRst(extRst)
  );

  task automatic step1();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    regAddr = a; regWe = 1'b1; regWdata = d;
    step1();
    regWe = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    regAddr = a; regRe = 1'b1; #1;
    d = regRdata;
    step1();
    regRe = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      oscTick = 1'b1; step1(); oscTick = 1'b0;
    end
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    #150000;
    nErr++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (3) step1();
    rstN = 1'b1;
    step1();

    // R1 reset state
    rd(1'b0, v); chk("R1 ctrl", v, 8'hA5);
    rd(1'b1, v); chk("R1 cnt", v, 0);
    chk("R1 coreRstReq", coreRstReq, 0);
    chk("R1 extRst", extRst, 0);

    // R2 disabled: ticks ignored
    ticks(3 * TPC);
    rd(1'b1, v); chk("R2 cnt idle", v, 0);
    chk("R2 no reset", extRst, 0);

    // R4 counting and R3 disable clears
    wr(1'b0, 8'h00);
    ticks(TPC + 3);
    rd(1'b1, v); chk("R4 one count", v, 1);
    wr(1'b0, 8'hA5);
    rd(1'b1, v); chk("R3 cnt cleared", v, 0);
    rd(1'b0, v); chk("R3 ctrl", v, 8'hA5);
    ticks(10);
    rd(1'b1, v); chk("R3 stopped", v, 0);
    wr(1'b0, 8'h00);
    ticks(TPC - 1);
    rd(1'b1, v); chk("R3 prescaler cleared", v, 0);
    ticks(1);
    rd(1'b1, v); chk("R3 first count", v, 1);
    wr(1'b0, 8'hA5);

    // R6 locked write ignored
    wr(1'b0, 8'h33);
    ticks(5);
    wr(1'b1, 8'h09);
    rd(1'b1, v); chk("R6 cnt kept", v, 0);
    rd(1'b0, v); chk("R6 ctrl kept", v, 8'h33);
    ticks(TPC - 5);
    rd(1'b1, v); chk("R6 prescaler kept", v, 1);
    wr(1'b0, 8'hA5);

    // R7 tick during access dropped, R8 read side effects
    wr(1'b0, 8'h00);
    ticks(TPC - 1);
    oscTick = 1'b1; rd(1'b1, v); oscTick = 1'b0;
    chk("R7 read value", v, 0);
    rd(1'b1, v); chk("R7 not deferred", v, 0);
    rd(1'b0, v); chk("R8 ctrl after read", v, 8'h00);
    ticks(1);
    rd(1'b1, v); chk("R8 prescaler intact", v, 1);
    oscTick = 1'b1; wr(1'b1, 8'h05); oscTick = 1'b0;
    ticks(TPC - 1);
    rd(1'b1, v); chk("R7 write drops tick", v, 1);
    ticks(1);
    rd(1'b1, v); chk("R7 count resumes", v, 2);
    wr(1'b0, 8'hA5);

    // R5 R9 R10 sweep over every reload value
    for (int r = 0; r < SPAN; r++) begin
      wr(1'b0, 8'h5A);
      wr(1'b1, 8'(r));
      rd(1'b0, v); chk("R5 ctrl zeroed", v, 0);
      rd(1'b1, v); chk("R5 loaded", v, r);
      ticks((SPAN - r) * TPC - 1);
      rd(1'b1, v); chk("R9 before wrap", v, SPAN - 1);
      chk("R9 no early req", coreRstReq, 0);
      ticks(1);
      chk("R9 req high", coreRstReq, 1);
      chk("R10 ext high", extRst, 1);
      rd(1'b0, v); chk("R9 ctrl rearmed", v, 8'hA5);
      rd(1'b1, v); chk("R9 cnt zero", v, 0);
      chk("R9 req one cycle", coreRstReq, 0);
      ticks(PT / 2);
      wr(1'b0, 8'hA5);
      ticks(PT - PT / 2 - 1);
      chk("R10 ext held", extRst, 1);
      ticks(1);
      chk("R10 ext released", extRst, 0);
    end

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule